// File: doc/BRIEF.md
# Peak-and-Hold Current Regulator Controller

This block is the digital control for one solenoid channel that is regulated by current. An external comparator reports when the load current has reached the threshold the block currently selects. The block decides when the switch gate is on, which of two threshold codes (peak or hold) the external DAC should present, and when the load looks shorted or of too low inductance. All durations are counted in microsecond ticks supplied on `usTick`.

When a channel is requested, the gate turns on at once. After a blanking interval the comparator flag ends each on-phase. A fixed off-time follows, and then the gate turns on again, with the blanking restarted. Four regulation modes decide when the threshold moves from peak to hold. The first current rise after a request is timed. If it reaches the threshold before one off-time has elapsed, a one-cycle overload pulse is issued. The configuration inputs are expected to be stable while the request is high.

Top module: `pnh_regulator`

## Requirements
- R1: While reset is held and just after it, `gateOn`, `usePeak` and `overloadPulse` are 0.
- R2: With `mode` = 00 (no regulation), `gateOn` equals `onReq` in the same cycle, `atThreshold` has no effect and `overloadPulse` stays 0.
- R3: With `mode` = 01 (hold only), `usePeak` stays 0. The gate stays on until a cycle where `atThreshold` is 1 outside blanking (the trip cycle). It is off from the next cycle for the off-time, then on again. This repeats while `onReq` is 1.
- R4: The off-time is `OFF_STEP`*(`offSel`+1) ticks: 00 = 100, 01 = 200, 10 = 300, 11 = 400. The gate is low from the cycle after the trip cycle until the cycle after the tick that completes that count.
- R5: With `mode` = 10 (peak and hold, minimum peak time), `usePeak` is 1 from the request until the first off-time ends. It is 0 from the next cycle on.
- R6: With `mode` = 11 (peak and hold, programmed peak time), `usePeak` is 1 until `PEAK_BASE`+`PEAK_STEP`*`peakSel` ticks after the request (000 = 800, 111 = 3600). On/off cycling continues throughout, and hold applies afterwards.
- R7: For `BLANK_TICKS` (20) ticks after every gate turn-on, whether it comes from the request or ends an off-time, `atThreshold` is ignored.
- R8: `overloadPulse` is a single-cycle pulse in the cycle after the first trip following a request. It is issued only when that trip comes before one off-time of ticks has elapsed since the request. Later trips never raise it.
- R9: When `onReq` falls, `gateOn` and `usePeak` are 0 in that same cycle. A new request restarts blanking, the first-edge check, the peak timer and the peak phase from scratch.
- R10: `levelSel` equals `peakLevel` while `usePeak` is 1, and `holdLevel` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| onReq | input | 1 | Channel on request |
| atThreshold | input | 1 | Comparator: load current reached the selected threshold |
| mode | input | 2 | Regulation mode (00 none, 01 hold, 10 min peak, 11 timed peak) |
| peakLevel | input | LVL_W | Peak current code |
| holdLevel | input | LVL_W | Hold current code |
| offSel | input | 2 | Fixed off-time code |
| peakSel | input | 3 | Peak time code |
| gateOn | output | 1 | Switch gate drive |
| usePeak | output | 1 | 1 when the peak threshold is selected |
| levelSel | output | LVL_W | Threshold code for the external DAC |
| overloadPulse | output | 1 | Overload / low-inductance fault pulse |

## Verification
A wrong off-time or blanking count appears at `gateOn` within one regulation period, as a gate edge one or more ticks early or late. A stuck or early peak phase appears on `usePeak` and `levelSel` at the first off-time end or at the peak timer expiry, up to 3600 ticks after the request. A mis-tracked first-edge state shows as a missing or extra `overloadPulse` one cycle after the trip. The reference model is compared with every output on every clock, so a divergence is caught in the cycle it first appears.

// File: rtl/pnh_pkg.sv
package pnh_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT     = 2'b00,
    MODE_HOLD       = 2'b01,
    MODE_PEAK_MIN   = 2'b10,
    MODE_PEAK_TIMED = 2'b11
  } regMode_t;

  // strobes from the control to the timer datapath
  typedef struct packed {
    logic clear;
    logic loadBlank;
    logic loadOff;
    logic loadWindow;
    logic loadPeak;
    logic runWindow;
    logic runPeak;
  } tmrCmd_t;

  // status flags returned by the timer datapath
  typedef struct packed {
    logic blankBusy;
    logic offLast;
    logic windowBusy;
    logic peakLast;
  } tmrStat_t;

endpackage

// File: rtl/pnh_downcnt.sv
module pnh_downcnt #(
  parameter int CNT_W       = 12,
  parameter bit REPORT_LAST = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             clear,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] loadVal,
  output logic             flag
);

  logic [CNT_W-1:0] cnt;
  logic             nonZero;

  assign nonZero = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)                          cnt <= '0;
    else if (clear)                     cnt <= '0;
    else if (load)                      cnt <= loadVal;
    else if (run && usTick && nonZero)  cnt <= cnt - 1'b1;
  end

  generate
    if (REPORT_LAST) begin : g_last
      assign flag = run && usTick && (cnt == CNT_W'(1));
    end else begin : g_busy
      assign flag = nonZero;
    end
  endgenerate

endmodule

// File: rtl/pnh_timers.sv
module pnh_timers
  import pnh_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int BLANK_TICKS = 20,
  parameter int OFF_STEP    = 100,
  parameter int PEAK_BASE   = 800,
  parameter int PEAK_STEP   = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  tmrCmd_t    cmd,
  input  logic [1:0] offSel,
  input  logic [2:0] peakSel,
  output tmrStat_t   stat
);

  localparam int NCNT       = 4;
  localparam int IDX_BLANK  = 0;
  localparam int IDX_OFF    = 1;
  localparam int IDX_WINDOW = 2;
  localparam int IDX_PEAK   = 3;
  localparam logic [NCNT-1:0] LAST_MASK = 4'b1010;

  logic [CNT_W-1:0] offTicks, peakTicks;
  logic [CNT_W-1:0] ldVal [NCNT];
  logic [NCNT-1:0]  ld, rn, flg;

  assign offTicks  = CNT_W'(OFF_STEP) * (CNT_W'(offSel) + CNT_W'(1));
  assign peakTicks = CNT_W'(PEAK_BASE) + CNT_W'(PEAK_STEP) * CNT_W'(peakSel);

  always_comb begin
    ldVal[IDX_BLANK]  = CNT_W'(BLANK_TICKS);
    ldVal[IDX_OFF]    = offTicks;
    ldVal[IDX_WINDOW] = offTicks;
    ldVal[IDX_PEAK]   = peakTicks;
    ld[IDX_BLANK]     = cmd.loadBlank;
    ld[IDX_OFF]       = cmd.loadOff;
    ld[IDX_WINDOW]    = cmd.loadWindow;
    ld[IDX_PEAK]      = cmd.loadPeak;
    rn[IDX_BLANK]     = 1'b1;
    rn[IDX_OFF]       = 1'b1;
    rn[IDX_WINDOW]    = cmd.runWindow;
    rn[IDX_PEAK]      = cmd.runPeak;
  end

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      pnh_downcnt #(.CNT_W(CNT_W), .REPORT_LAST(LAST_MASK[i])) cnt_i (
        .clk(clk), .rstN(rstN), .usTick(usTick), .clear(cmd.clear),
        .load(ld[i]), .run(rn[i]), .loadVal(ldVal[i]), .flag(flg[i])
      );
    end
  endgenerate

  assign stat.blankBusy  = flg[IDX_BLANK];
  assign stat.offLast    = flg[IDX_OFF];
  assign stat.windowBusy = flg[IDX_WINDOW];
  assign stat.peakLast   = flg[IDX_PEAK];

endmodule

// File: rtl/pnh_ctrl.sv
module pnh_ctrl
  import pnh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       onReq,
  input  logic       atThreshold,
  input  logic [1:0] mode,
  input  tmrStat_t   stat,
  output tmrCmd_t    cmd,
  output logic       gateOn,
  output logic       usePeak,
  output logic       overloadPulse
);

  logic active, offPhase, peakPhase, firstEdge;
  logic start, regOn, trip, offEnd, peakEnd;

  always_comb begin
    start   = onReq && !active;
    regOn   = onReq && active && (mode != MODE_DIRECT);
    trip    = regOn && !offPhase && !stat.blankBusy && atThreshold;
    offEnd  = regOn && offPhase && stat.offLast;
    cmd.clear      = !onReq;
    cmd.loadBlank  = start || offEnd;
    cmd.loadOff    = trip;
    cmd.loadWindow = start;
    cmd.loadPeak   = start;
    cmd.runWindow  = firstEdge;
    cmd.runPeak    = active && peakPhase && (mode == MODE_PEAK_TIMED);
    peakEnd = onReq && cmd.runPeak && stat.peakLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active        <= 1'b0;
      offPhase      <= 1'b0;
      peakPhase     <= 1'b0;
      firstEdge     <= 1'b0;
      overloadPulse <= 1'b0;
    end else begin
      overloadPulse <= 1'b0;
      if (!onReq) begin
        active    <= 1'b0;
        offPhase  <= 1'b0;
        peakPhase <= 1'b0;
        firstEdge <= 1'b0;
      end else if (start) begin
        active    <= 1'b1;
        offPhase  <= 1'b0;
        peakPhase <= mode[1];
        firstEdge <= (mode != MODE_DIRECT);
      end else begin
        if (trip) begin
          offPhase      <= 1'b1;
          firstEdge     <= 1'b0;
          overloadPulse <= firstEdge && stat.windowBusy;
        end
        if (offEnd) begin
          offPhase <= 1'b0;
          if (mode == MODE_PEAK_MIN) peakPhase <= 1'b0;
        end
        if (peakEnd) peakPhase <= 1'b0;
      end
    end
  end

  assign gateOn  = onReq && !offPhase;
  assign usePeak = onReq && (active ? peakPhase : mode[1]);

endmodule

// File: rtl/pnh_regulator.sv
module pnh_regulator
  import pnh_pkg::*;
#(
  parameter int LVL_W       = 2,
  parameter int CNT_W       = 12,
  parameter int BLANK_TICKS = 20,
  parameter int OFF_STEP    = 100,
  parameter int PEAK_BASE   = 800,
  parameter int PEAK_STEP   = 400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             onReq,
  input  logic             atThreshold,
  input  logic [1:0]       mode,
  input  logic [LVL_W-1:0] peakLevel,
  input  logic [LVL_W-1:0] holdLevel,
  input  logic [1:0]       offSel,
  input  logic [2:0]       peakSel,
  output logic             gateOn,
  output logic             usePeak,
  output logic [LVL_W-1:0] levelSel,
  output logic             overloadPulse
);

  tmrCmd_t  cmd;
  tmrStat_t stat;

  pnh_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .onReq(onReq), .atThreshold(atThreshold),
    .mode(mode), .stat(stat), .cmd(cmd), .gateOn(gateOn),
    .usePeak(usePeak), .overloadPulse(overloadPulse)
  );

  pnh_timers #(
    .CNT_W(CNT_W), .BLANK_TICKS(BLANK_TICKS), .OFF_STEP(OFF_STEP),
    .PEAK_BASE(PEAK_BASE), .PEAK_STEP(PEAK_STEP)
  ) timers_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .cmd(cmd),
    .offSel(offSel), .peakSel(peakSel), .stat(stat)
  );

  assign levelSel = usePeak ? peakLevel : holdLevel;

endmodule

// File: rtl/pnh_regulator_chk.sv
module pnh_regulator_chk (
  input logic       clk,
  input logic       rstN,
  input logic       onReq,
  input logic [1:0] mode,
  input logic       gateOn,
  input logic       usePeak,
  input logic       overloadPulse
);

  assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    overloadPulse |=> !overloadPulse);

  assert_fault_after_on_R8: assert property (@(posedge clk) disable iff (!rstN)
    overloadPulse |-> $past(onReq && gateOn && mode != 2'b00));

  assert_direct_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (onReq && mode == 2'b00) |-> (gateOn && !overloadPulse));

  assert_drop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !onReq |-> (!gateOn && !usePeak));

  assert_blank_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |=> (gateOn || !onReq));

  assert_hold_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (onReq && mode == 2'b01) |-> !usePeak);

endmodule

bind pnh_regulator pnh_regulator_chk chk_i (.*);

// File: tb/pnh_regulator_tb.sv
`timescale 1ns/1ps
module pnh_regulator_tb_top;

  localparam int BLANK = 20;
  localparam int OFFSTEP = 100;
  localparam int PKBASE = 800;
  localparam int PKSTEP = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic onReq = 1'b0;
  logic atThreshold = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] peakLevel = 2'd3;
  logic [1:0] holdLevel = 2'd1;
  logic [1:0] offSel = 2'b00;
  logic [2:0] peakSel = 3'b000;
  logic gateOn, usePeak, overloadPulse;
  logic [1:0] levelSel;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  int tickDiv = 1;
  bit loadSim = 1'b0;
  int curr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pnh_regulator dut_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .onReq(onReq),
    .atThreshold(atThreshold), .mode(mode), .peakLevel(peakLevel),
    .holdLevel(holdLevel), .offSel(offSel), .peakSel(peakSel),
    .gateOn(gateOn), .usePeak(usePeak), .levelSel(levelSel),
    .overloadPulse(overloadPulse)
  );

  // reference model: remaining-tick integers per activity
  bit mAct, mOff, mPk, mFirst, mFault;
  int mBlank, mOffLeft, mWin, mPkLeft;

  function automatic int offTicks();
    return OFFSTEP * (int'(offSel) + 1);
  endfunction
  function automatic int peakTicks();
    return PKBASE + PKSTEP * int'(peakSel);
  endfunction
  function automatic int mGate();
    return (onReq && !mOff) ? 1 : 0;
  endfunction
  function automatic int mUse();
    if (!onReq) return 0;
    return mAct ? int'(mPk) : int'(mode[1]);
  endfunction
  function automatic int mLevel();
    return (mUse() != 0) ? int'(peakLevel) : int'(holdLevel);
  endfunction

  always @(posedge clk) begin
    bit oOff, oFirst, oPk;
    int oBlank, oWin, oOffLeft;
    if (!rstN) begin
      mAct = 0; mOff = 0; mPk = 0; mFirst = 0; mFault = 0;
      mBlank = 0; mOffLeft = 0; mWin = 0; mPkLeft = 0;
    end else begin
      mFault = 0;
      if (!onReq) begin
        mAct = 0; mOff = 0; mPk = 0; mFirst = 0;
        mBlank = 0; mOffLeft = 0; mWin = 0; mPkLeft = 0;
      end else if (!mAct) begin
        mAct = 1; mOff = 0; mPk = mode[1]; mFirst = (mode != 2'b00);
        mBlank = BLANK; mWin = offTicks(); mPkLeft = peakTicks(); mOffLeft = 0;
      end else if (mode != 2'b00) begin
        oOff = mOff; oFirst = mFirst; oPk = mPk;
        oBlank = mBlank; oWin = mWin; oOffLeft = mOffLeft;
        if (usTick && oBlank > 0) mBlank = oBlank - 1;
        if (oFirst && usTick && oWin > 0) mWin = oWin - 1;
        if (!oOff && oBlank == 0 && atThreshold) begin
          mOff = 1; mOffLeft = offTicks();
          if (oFirst && oWin > 0) mFault = 1;
          mFirst = 0;
        end else if (oOff && usTick) begin
          if (oOffLeft == 1) begin
            mOff = 0; mBlank = BLANK;
            if (mode == 2'b10) mPk = 0;
          end
          mOffLeft = oOffLeft - 1;
        end
        if (mode == 2'b11 && oPk && usTick && mPkLeft > 0) begin
          if (mPkLeft == 1) mPk = 0;
          mPkLeft = mPkLeft - 1;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic compareAll();
    chk("R3", "gateOn vs model", int'(gateOn), mGate());
    chk("R5", "usePeak vs model", int'(usePeak), mUse());
    chk("R10", "levelSel vs model", int'(levelSel), mLevel());
    chk("R8", "overloadPulse vs model", int'(overloadPulse), int'(mFault));
  endtask

  task automatic look();
    #1;
    compareAll();
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      usTick = ((cyc % tickDiv) == 0);
      if (loadSim) begin
        if (mGate() != 0) curr = curr + 3; else curr = curr - 1;
        if (curr < 0) curr = 0;
        if (curr > 400) curr = 400;
        atThreshold = (curr >= (mLevel() + 1) * 40);
      end
      look();
    end
  endtask

  task automatic dropReq();
    onReq = 1'b0;
    look();
    step(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "gateOn in reset", int'(gateOn), 0);
    chk("R1", "usePeak in reset", int'(usePeak), 0);
    chk("R1", "overloadPulse in reset", int'(overloadPulse), 0);
    @(negedge clk);
    rstN = 1'b1;
    step(2);
    chk("R1", "gateOn after reset", int'(gateOn), 0);

    // R2: direct mode, comparator ignored
    mode = 2'b00; atThreshold = 1'b1; onReq = 1'b1; look();
    chk("R2", "gate follows request at once", int'(gateOn), 1);
    step(50);
    chk("R2", "gate still on", int'(gateOn), 1);
    chk("R2", "no fault", int'(overloadPulse), 0);
    onReq = 1'b0; look();
    chk("R2", "gate drops with request", int'(gateOn), 0);
    step(3);

    // R3 / R4 / R7 / R8: hold only, 200-tick off-time, comparator always high
    mode = 2'b01; offSel = 2'b01; atThreshold = 1'b1; onReq = 1'b1; look();
    step(20);
    chk("R7", "blanked at +20", int'(gateOn), 1);
    step(1);
    chk("R7", "trip cycle gate on at +21", int'(gateOn), 1);
    step(1);
    chk("R3", "gate off after trip", int'(gateOn), 0);
    chk("R8", "early first edge fault", int'(overloadPulse), 1);
    chk("R3", "hold only uses hold", int'(usePeak), 0);
    step(199);
    chk("R4", "still off at end of 200 ticks", int'(gateOn), 0);
    step(1);
    chk("R4", "gate back on after 200 ticks", int'(gateOn), 1);
    step(20);
    chk("R7", "blanked after internal turn-on", int'(gateOn), 1);
    step(1);
    chk("R3", "second trip ends on-phase", int'(gateOn), 0);
    chk("R8", "no fault on later edge", int'(overloadPulse), 0);
    step(300);
    dropReq();

    // R8: late first edge gives no fault
    offSel = 2'b00; atThreshold = 1'b0; onReq = 1'b1; look();
    step(150);
    atThreshold = 1'b1; look();
    step(1);
    chk("R3", "late trip turns gate off", int'(gateOn), 0);
    chk("R8", "late first edge no fault", int'(overloadPulse), 0);
    step(10);

    // R9: drop inside off-phase, restart in min-peak mode
    onReq = 1'b0; look();
    chk("R9", "gate off on drop", int'(gateOn), 0);
    chk("R9", "usePeak off on drop", int'(usePeak), 0);
    step(3);
    mode = 2'b10; onReq = 1'b1; look();
    chk("R9", "restart gate on", int'(gateOn), 1);
    chk("R5", "min peak starts on peak", int'(usePeak), 1);
    step(22);
    chk("R9", "fresh first-edge fault", int'(overloadPulse), 1);
    step(99);
    chk("R5", "peak through first off-time", int'(usePeak), 1);
    chk("R4", "100-tick off still off", int'(gateOn), 0);
    step(1);
    chk("R5", "hold after first off-time", int'(usePeak), 0);
    chk("R10", "level is hold code", int'(levelSel), 1);
    step(200);
    dropReq();

    // R6: timed peak, 800 ticks
    mode = 2'b11; peakSel = 3'b000; atThreshold = 1'b1; onReq = 1'b1; look();
    step(800);
    chk("R6", "peak at 800", int'(usePeak), 1);
    chk("R10", "level is peak code", int'(levelSel), 3);
    step(1);
    chk("R6", "hold after 800", int'(usePeak), 0);
    chk("R10", "level is hold code after peak", int'(levelSel), 1);
    step(50);
    dropReq();

    // R6: timed peak, 3600 ticks, load model drives the comparator
    peakSel = 3'b111; loadSim = 1'b1; onReq = 1'b1; look();
    step(3600);
    chk("R6", "peak at 3600", int'(usePeak), 1);
    step(1);
    chk("R6", "hold after 3600", int'(usePeak), 0);
    step(600);
    dropReq();

    // sparse ticks, hold and min-peak with load model
    tickDiv = 3; mode = 2'b01; offSel = 2'b11; onReq = 1'b1; look();
    step(3000);
    dropReq();
    mode = 2'b10; offSel = 2'b10; peakLevel = 2'd2; holdLevel = 2'd0;
    onReq = 1'b1; look();
    step(3000);
    dropReq();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule